// File: doc/BRIEF.md
# Stepped Clock Frequency Ramp Controller

This block sits between the clock configuration logic and the divider that feeds the core bus. When software asks for a large step up in frequency, it does not apply the new divider at once. Such a step happens when the system clock moves onto the PLL or when the bus prescaler drops from a large to a small divide. Instead, the block lowers the divider exponent one position at a time and holds each intermediate setting for a dwell period. This spreads the change in supply current over many cycles.

While the ramp runs, the block holds the core bus in a halted state. Interrupt lines are masked toward the interrupt controller, but any request seen during the ramp is remembered and presented again on the first cycle after the bus resumes. DMA request lines pass through untouched at all times. A request that needs no ramp is applied on the next clock edge with no halt. Examples are a downward change in frequency, an unchanged divider, or any request while the feature is disabled.

Top module: `clk_ramp_ctrl`

## Requirements
- R1: A ramp starts on a `sw_req` cycle only when `ramp_en` is 1 and either `src_to_pll` is 1 or `tgt_code` is smaller than `cur_code`; codes are the base-2 logarithm of the divide ratio (4 bits by default, 0 = divide by 1).
- R2: Every other accepted request writes `tgt_code` to `app_code` on the accepting clock edge, with `bus_halt` and `ramp_done` staying 0.
- R3: On the edge that accepts a ramp, `app_code` takes the start code and `bus_halt` rises. The start code is `cur_code`, except on a PLL switch, where it is the larger of `cur_code` and `tgt_code`+1 (saturating at the all-ones code). If the start code is not above the target, the request takes the R2 path.
- R4: During a ramp, `app_code` only ever decreases by exactly one, and each value from the start code down to target+1 is held for exactly one dwell period.
- R5: The dwell period in clock cycles is `dwell_len`, captured when the ramp is accepted; a value of 0 selects the default of 64 cycles.
- R6: `bus_halt` falls on the same edge that applies the target code, so it stays high for (start − target) × dwell cycles.
- R7: `ramp_done` is high for exactly the one cycle right after `bus_halt` falls, and never otherwise.
- R8: A `sw_req` arriving while `bus_halt` is high is ignored: the ramp sequence and the final code are unchanged.
- R9: While `bus_halt` is high, `irq_out` is all zeros. Each `irq_in` bit seen high at any clock edge during the ramp is ORed into `irq_out` for the single cycle that follows the release.
- R10: While `bus_halt` is low, `irq_out` follows `irq_in` combinationally.
- R11: `dma_req_out` equals `dma_req_in` in every cycle, including during a ramp.
- R12: After reset, `app_code` is 0, `bus_halt` and `ramp_done` are 0, and no interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ramp_en | input | 1 | Enables stepped ramping |
| src_to_pll | input | 1 | The request is a source switch onto the PLL |
| sw_req | input | 1 | One-cycle request to apply `tgt_code` |
| cur_code | input | 4 | Divider exponent before the change |
| tgt_code | input | 4 | Divider exponent wanted after the change |
| dwell_len | input | 8 | Cycles per intermediate step, 0 = default |
| irq_in | input | 4 | Raw interrupt request lines |
| dma_req_in | input | 2 | DMA request lines |
| app_code | output | 4 | Divider exponent currently applied |
| bus_halt | output | 1 | Core bus halt, high during a ramp |
| ramp_done | output | 1 | One-cycle pulse when a ramp completes |
| irq_out | output | 4 | Interrupt lines toward the interrupt controller |
| dma_req_out | output | 2 | DMA request lines, passed through |

## Verification
A step counter that is off by one shows up on `app_code` at the first step boundary, one dwell after the request. A wrong decrement or a stale target shows up as a wrong code on the very next step. A broken state register shows up as `bus_halt` releasing early or staying high past the last step. This makes `ramp_done` arrive in the wrong cycle, which the cycle-exact scoreboard catches at once. A pending bit that is lost or never cleared appears only in the first cycle after the release, so the bench raises an interrupt mid-ramp and compares that specific cycle.

// File: rtl/clk_ramp_pkg.sv
package clk_ramp_pkg;

   // controller phase
   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_STEP = 1'b1
   } ramp_phase_e;

endpackage

// File: rtl/ramp_trigger.sv
// Decides whether an incoming request needs a stepped ramp and from where.
module ramp_trigger #(
   parameter int EXP_W        = 4,
   parameter bit PLL_MIN_STEP = 1'b1
) (
   input  logic             ramp_en,
   input  logic             src_to_pll,
   input  logic [EXP_W-1:0] cur_code,
   input  logic [EXP_W-1:0] tgt_code,
   output logic [EXP_W-1:0] start_code,
   output logic             need_ramp
);
   localparam logic [EXP_W-1:0] TOP_CODE = '1;
   localparam logic [EXP_W-1:0] ONE_CODE = EXP_W'(1);

   if (EXP_W < 1) begin : g_bad_exp
      $error("ramp_trigger: EXP_W must be at least 1");
   end

   logic [EXP_W-1:0] tgt_up;

   always_comb begin
      if (tgt_code == TOP_CODE) tgt_up = tgt_code;
      else                      tgt_up = tgt_code + ONE_CODE;
   end

   generate
      if (PLL_MIN_STEP) begin : g_pll_floor
         // a PLL switch always passes through at least one slower step
         always_comb begin
            if (src_to_pll && (tgt_up > cur_code)) start_code = tgt_up;
            else                                   start_code = cur_code;
         end
      end else begin : g_pll_plain
         logic unused_pll;
         assign unused_pll = src_to_pll ^ (^tgt_up);
         always_comb start_code = cur_code;
      end
   endgenerate

   always_comb begin
      need_ramp = ramp_en && (start_code > tgt_code);
   end

endmodule

// File: rtl/dwell_sel.sv
// Selects the number of cycles each intermediate step is held.
module dwell_sel #(
   parameter int CNT_W      = 8,
   parameter int DEF_DWELL  = 64,
   parameter bit DWELL_PROG = 1'b1
) (
   input  logic [CNT_W-1:0] dwell_len,
   output logic [CNT_W-1:0] dwell_eff
);
   localparam logic [CNT_W-1:0] DEF_CODE = CNT_W'(DEF_DWELL);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("dwell_sel: CNT_W must be at least 2");
   end
   if (DEF_DWELL < 1 || DEF_DWELL >= (1 << CNT_W)) begin : g_bad_def
      $error("dwell_sel: DEF_DWELL must fit in CNT_W bits and be nonzero");
   end

   generate
      if (DWELL_PROG) begin : g_prog
         always_comb begin
            if (dwell_len == '0) dwell_eff = DEF_CODE;
            else                 dwell_eff = dwell_len;
         end
      end else begin : g_fixed
         logic unused_len;
         assign unused_len = ^dwell_len;
         always_comb dwell_eff = DEF_CODE;
      end
   endgenerate

endmodule

// File: rtl/ramp_stepper.sv
// Walks the applied exponent down one position per dwell period.
module ramp_stepper
   import clk_ramp_pkg::*;
#(
   parameter int EXP_W    = 4,
   parameter int CNT_W    = 8,
   parameter int RST_CODE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_req,
   input  logic             need_ramp,
   input  logic [EXP_W-1:0] start_code,
   input  logic [EXP_W-1:0] tgt_code,
   input  logic [CNT_W-1:0] dwell_eff,
   output logic [EXP_W-1:0] app_code,
   output logic             halt,
   output logic             done
);
   localparam logic [EXP_W-1:0] RST_VAL  = EXP_W'(RST_CODE);
   localparam logic [EXP_W-1:0] ONE_CODE = EXP_W'(1);
   localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

   if (RST_CODE < 0 || RST_CODE >= (1 << EXP_W)) begin : g_bad_rst
      $error("ramp_stepper: RST_CODE out of range");
   end

   ramp_phase_e      phase;
   logic [EXP_W-1:0] tgt_q;
   logic [CNT_W-1:0] dwell_q;
   logic [CNT_W-1:0] cnt;
   logic [EXP_W-1:0] next_code;
   logic             step_end;

   always_comb begin
      next_code = app_code - ONE_CODE;
      step_end  = (cnt == dwell_q - ONE_CNT);
      halt      = (phase == PH_STEP);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         app_code <= RST_VAL;
         tgt_q    <= RST_VAL;
         dwell_q  <= ONE_CNT;
         cnt      <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (sw_req) begin
                  tgt_q <= tgt_code;
                  if (need_ramp) begin
                     app_code <= start_code;
                     dwell_q  <= dwell_eff;
                     cnt      <= '0;
                     phase    <= PH_STEP;
                  end else begin
                     app_code <= tgt_code;
                  end
               end
            end
            PH_STEP: begin
               if (step_end) begin
                  cnt      <= '0;
                  app_code <= next_code;
                  if (next_code == tgt_q) begin
                     phase <= PH_IDLE;
                     done  <= 1'b1;
                  end
               end else begin
                  cnt <= cnt + ONE_CNT;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R6
   halt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(halt) |-> (app_code == tgt_q));

   // R4
   step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(halt) && (app_code != $past(app_code))) |->
         (app_code == $past(app_code) - ONE_CODE));

   // R7
   done_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   done_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!halt && $past(halt)));

   // R5
   dwell_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> (cnt < dwell_q));

   // R8
   target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && $past(halt)) |-> $stable(tgt_q));

endmodule

// File: rtl/irq_hold.sv
// Masks interrupt lines during a ramp and replays what arrived once released.
module irq_hold #(
   parameter int IRQ_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             halt,
   input  logic [IRQ_W-1:0] irq_in,
   output logic [IRQ_W-1:0] irq_out
);
   if (IRQ_W < 1) begin : g_bad_irq
      $error("irq_hold: IRQ_W must be at least 1");
   end

   logic [IRQ_W-1:0] pend;

   generate
      for (genvar i = 0; i < IRQ_W; i++) begin : g_line
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    pend[i] <= 1'b0;
            else if (halt) pend[i] <= pend[i] | irq_in[i];
            else           pend[i] <= 1'b0;
         end

         always_comb begin
            if (halt) irq_out[i] = 1'b0;
            else      irq_out[i] = irq_in[i] | pend[i];
         end
      end
   endgenerate

   // R9
   pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && $past(halt)) |-> ((pend & $past(pend)) == $past(pend)));

   // R9
   replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(halt) |-> ((irq_out & pend) == pend));

endmodule

// File: rtl/clk_ramp_ctrl.sv
// Top level of the stepped clock frequency ramp controller.
module clk_ramp_ctrl #(
   parameter int EXP_W        = 4,
   parameter int CNT_W        = 8,
   parameter int DEF_DWELL    = 64,
   parameter bit DWELL_PROG   = 1'b1,
   parameter bit PLL_MIN_STEP = 1'b1,
   parameter int IRQ_W        = 4,
   parameter int DMA_W        = 2,
   parameter int RST_CODE     = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ramp_en,
   input  logic             src_to_pll,
   input  logic             sw_req,
   input  logic [EXP_W-1:0] cur_code,
   input  logic [EXP_W-1:0] tgt_code,
   input  logic [CNT_W-1:0] dwell_len,
   input  logic [IRQ_W-1:0] irq_in,
   input  logic [DMA_W-1:0] dma_req_in,
   output logic [EXP_W-1:0] app_code,
   output logic             bus_halt,
   output logic             ramp_done,
   output logic [IRQ_W-1:0] irq_out,
   output logic [DMA_W-1:0] dma_req_out
);
   if (DMA_W < 1) begin : g_bad_dma
      $error("clk_ramp_ctrl: DMA_W must be at least 1");
   end

   logic [EXP_W-1:0] start_code;
   logic             need_ramp;
   logic [CNT_W-1:0] dwell_eff;
   logic             halt_w;

   ramp_trigger #(
      .EXP_W        (EXP_W),
      .PLL_MIN_STEP (PLL_MIN_STEP)
   ) u_trig (
      .ramp_en    (ramp_en),
      .src_to_pll (src_to_pll),
      .cur_code   (cur_code),
      .tgt_code   (tgt_code),
      .start_code (start_code),
      .need_ramp  (need_ramp)
   );

   dwell_sel #(
      .CNT_W      (CNT_W),
      .DEF_DWELL  (DEF_DWELL),
      .DWELL_PROG (DWELL_PROG)
   ) u_dwell (
      .dwell_len (dwell_len),
      .dwell_eff (dwell_eff)
   );

   ramp_stepper #(
      .EXP_W    (EXP_W),
      .CNT_W    (CNT_W),
      .RST_CODE (RST_CODE)
   ) u_step (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_req     (sw_req),
      .need_ramp  (need_ramp),
      .start_code (start_code),
      .tgt_code   (tgt_code),
      .dwell_eff  (dwell_eff),
      .app_code   (app_code),
      .halt       (halt_w),
      .done       (ramp_done)
   );

   irq_hold #(
      .IRQ_W (IRQ_W)
   ) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .halt    (halt_w),
      .irq_in  (irq_in),
      .irq_out (irq_out)
   );

   // DMA requests never wait on the ramp
   assign dma_req_out = dma_req_in;
   assign bus_halt    = halt_w;

endmodule

// File: tb/clk_ramp_ctrl_test.sv
module clk_ramp_ctrl_test;

   typedef struct {
      int    code;
      int    halt;
      int    done;
      int    irq;
      string tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ramp_en = 1'b0;
   logic       src_to_pll = 1'b0;
   logic       sw_req = 1'b0;
   logic [3:0] cur_code = 4'd0;
   logic [3:0] tgt_code = 4'd0;
   logic [7:0] dwell_len = 8'd0;
   logic [3:0] irq_in = 4'd0;
   logic [1:0] dma_req_in = 2'd0;
   logic [3:0] app_code;
   logic       bus_halt;
   logic       ramp_done;
   logic [3:0] irq_out;
   logic [1:0] dma_req_out;

   int   checks = 0;
   int   errors = 0;
   exp_t q[$];

   always #10 clk = ~clk;

   clk_ramp_ctrl uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .ramp_en     (ramp_en),
      .src_to_pll  (src_to_pll),
      .sw_req      (sw_req),
      .cur_code    (cur_code),
      .tgt_code    (tgt_code),
      .dwell_len   (dwell_len),
      .irq_in      (irq_in),
      .dma_req_in  (dma_req_in),
      .app_code    (app_code),
      .bus_halt    (bus_halt),
      .ramp_done   (ramp_done),
      .irq_out     (irq_out),
      .dma_req_out (dma_req_out)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // monitor: pops one expected item per cycle, away from the clock edge
   always @(negedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (int'(app_code) != e.code || int'(bus_halt) != e.halt ||
             int'(ramp_done) != e.done || int'(irq_out) != e.irq) begin
            errors++;
            $display("FAIL %s: actual code=%0d halt=%0d done=%0d irq=%0d expected code=%0d halt=%0d done=%0d irq=%0d",
                     e.tag, app_code, bus_halt, ramp_done, irq_out,
                     e.code, e.halt, e.done, e.irq);
         end
      end
      if (bus_halt) chk("R11 dma during ramp", int'(dma_req_out), int'(dma_req_in));
   end

   // driver: issue one request, push expected per-cycle results, stir inputs
   task automatic do_req(input string tag, input bit en, input bit pll,
                         input int cur, input int tgt, input int dw,
                         input int irq_at, input int imask, input int poke_at);
      int s, d, n, span;
      bit ramp;
      exp_t e;
      s = cur;
      if (pll) begin
         int up;
         up = (tgt == 15) ? 15 : tgt + 1;
         if (up > s) s = up;
      end
      ramp = en && (s > tgt);
      d    = (dw == 0) ? 64 : dw;
      n    = s - tgt;
      @(negedge clk);
      ramp_en    = en;
      src_to_pll = pll;
      cur_code   = 4'(cur);
      tgt_code   = 4'(tgt);
      dwell_len  = 8'(dw);
      sw_req     = 1'b1;
      @(posedge clk);
      #1 sw_req = 1'b0;
      e.tag = tag;
      if (ramp) begin
         span = n * d;
         for (int j = 0; j < span; j++) begin
            e.code = s - j / d; e.halt = 1; e.done = 0; e.irq = 0;
            q.push_back(e);
         end
         e.code = tgt; e.halt = 0; e.done = 1;
         e.irq  = (irq_at >= 0 && irq_at < span) ? imask : 0;
         q.push_back(e);
         e.done = 0; e.irq = 0;
         q.push_back(e);
         for (int i = 0; i < span + 2; i++) begin
            @(negedge clk);
            irq_in     = (i == irq_at) ? 4'(imask) : 4'd0;
            dma_req_in = 2'(i);
            if (i == poke_at) begin
               sw_req   = 1'b1;
               tgt_code = 4'd1;
            end else begin
               sw_req = 1'b0;
            end
         end
      end else begin
         e.code = tgt; e.halt = 0; e.done = 0; e.irq = 0;
         q.push_back(e);
         e.tag = {tag, " hold"};
         q.push_back(e);
      end
      wait (q.size() == 0);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 code", int'(app_code), 0);
      chk("R12 halt", int'(bus_halt), 0);
      chk("R12 done", int'(ramp_done), 0);
      chk("R12 irq", int'(irq_out), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 passthrough while idle
      irq_in = 4'b1010;
      #1 chk("R10 irq idle", int'(irq_out), 10);
      @(negedge clk);
      irq_in = 4'b0000;
      dma_req_in = 2'b11;
      #1 chk("R11 dma idle", int'(dma_req_out), 3);

      // R2 disabled feature: immediate even for a large upward jump
      do_req("R2 disabled", 1'b0, 1'b0, 0, 6, 4, -1, 0, -1);
      do_req("R2 disabled back", 1'b0, 1'b0, 6, 9, 4, -1, 0, -1);
      // R2 downward frequency change with feature on
      do_req("R2 downward", 1'b1, 1'b0, 9, 12, 4, -1, 0, -1);
      // R1 R4 R6 R7 R8 R9: prescaler ramp 12->8, dwell 4, irq mid ramp, poke
      do_req("R4 ramp 12to8", 1'b1, 1'b0, 12, 8, 4, 3, 5, 6);
      // R5 dwell 0 selects 64
      do_req("R5 default dwell", 1'b1, 1'b0, 8, 6, 0, 70, 8, 100);
      // R3 PLL switch with equal codes steps through target+1
      do_req("R3 pll equal", 1'b1, 1'b1, 6, 6, 3, -1, 0, -1);
      // R2 equal codes without PLL: immediate
      do_req("R2 equal", 1'b1, 1'b0, 6, 6, 3, -1, 0, -1);
      // R3 PLL switch at the top code saturates: no ramp
      do_req("R3 pll top", 1'b1, 1'b1, 6, 15, 3, -1, 0, -1);
      // R1 PLL switch with feature off: immediate
      do_req("R1 pll off", 1'b0, 1'b1, 15, 2, 3, -1, 0, -1);
      // R3 PLL switch from above the target starts at cur_code
      do_req("R3 pll above", 1'b1, 1'b1, 5, 2, 2, 0, 15, -1);
      // R4 full span 15 to 0, dwell 2
      do_req("R4 full span", 1'b1, 1'b0, 15, 0, 2, 28, 1, 10);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule